// File: doc/BRIEF.md
# Single-Precision Float to 64-bit Integer Converter

This unit turns an IEEE-754 binary32 operand into a signed 64-bit two's-complement integer. The rounding direction is chosen for each operand. It also reports two exception flags: invalid-operation and inexact. The operand first goes through a classification stage, then an alignment stage, then a rounding stage. The final result and the flags are captured in one register stage, so a result appears one clock after its operand is presented.

Inputs that cannot be represented do not wrap. NaN operands produce one fixed saturated pattern. Infinities and out-of-range finite values produce the saturated value that matches their sign. The single finite value that sits exactly on the negative limit is accepted without any flag. Zero and subnormal operands are both flushed to a zero result with no flags raised.

Top module: `f2i_conv`

## Requirements
- R1: A NaN operand (exponent field all ones, fraction nonzero, either sign) yields result 0x7FFF_FFFF_FFFF_FFFF with invalid_o=1 and inexact_o=0.
- R2: An infinite operand yields invalid_o=1 and inexact_o=0. The result is 0x7FFF_FFFF_FFFF_FFFF for +inf and 0x8000_0000_0000_0000 for -inf.
- R3: An operand whose exponent field is zero (a zero or a subnormal of either sign) yields result 0 with both flags clear.
- R4: A finite operand with unbiased exponent of 63 or more yields invalid_o=1 and the saturated value for its sign. The one exception is operand 0xDF00_0000 (exactly -2^63), which yields 0x8000_0000_0000_0000 with both flags clear.
- R5: A finite operand with unbiased exponent from 23 to 62 is an exact integer. It converts with both flags clear, and a negative sign gives the two's complement of the magnitude.
- R6: With rm_i=2'b00 (nearest), a fraction above one half rounds the magnitude up. A fraction of exactly one half rounds to the even integer.
- R7: With rm_i=2'b01 (toward zero), the fractional part is dropped and the magnitude never increases.
- R8: With rm_i=2'b10 (toward +inf), a positive inexact magnitude increases by one and a negative one is truncated.
- R9: With rm_i=2'b11 (toward -inf), a negative inexact magnitude increases by one and a positive one is truncated.
- R10: inexact_o is 1 exactly when a nonzero fraction was discarded and invalid_o is 0. The two flags are never both set.
- R11: A magnitude below one half (unbiased exponent below -1) is treated as a pure sticky remainder. It gives 0 under nearest and toward zero, and ±1 only under the directed mode that points away from zero.
- R12: valid_o is valid_i delayed by one clock. Result and flags belong to the operand presented on the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| op_i | input | 32 | binary32 operand |
| rm_i | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | 64 | Signed integer result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The bench targets four areas. The first is ties such as 0.5, 1.5, 2.5 and 8388607.5: a design that rounds half away from zero, or ignores the odd bit, returns the wrong neighbour there. The second is the boundary near 2^63: it checks that 0xDF00_0000 converts cleanly to the negative limit, while +2^63 and the next negative value saturate with invalid set; an off-by-one exponent compare breaks one of these three. The third is negative operands under both directed modes, including tiny normals and -0.5, which catch rounding applied after negation rather than to the magnitude. The fourth is subnormal operands and NaNs with the sign bit set, which expose a missing flush or a sign-dependent NaN pattern.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int INT_W  = 64;
  localparam int OP_W   = EXP_W + FRAC_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int UEXP_W = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] POS_LIM = ~NEG_LIM;
  localparam logic [INT_W-1:0] NAN_VAL = POS_LIM;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO,
    CL_NORM,
    CL_INF,
    CL_NAN
  } fclass_e;

  typedef struct packed {
    logic             sign;
    fclass_e          cls;
    logic [SIG_W-1:0] sig;
  } fdec_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  output fdec_t             dec_o,
  output logic [UEXP_W-1:0] uexp_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_zero;

  assign exp_f    = op_i[FRAC_W +: EXP_W];
  assign frac_f   = op_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;

  always_comb begin
    dec_o.sign = op_i[OP_W-1];
    dec_o.sig  = {1'b1, frac_f};
    if (exp_ones)      dec_o.cls = (|frac_f) ? CL_NAN : CL_INF;
    else if (exp_zero) dec_o.cls = CL_ZERO;   // subnormals flushed
    else               dec_o.cls = CL_NORM;
  end

  // unbiased exponent, two's complement, two guard bits
  assign uexp_o = {2'b00, exp_f} - UEXP_W'(BIAS);
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [UEXP_W-1:0] uexp_i,
  output logic [INT_W-1:0]  mag_o,
  output logic              rnd_o,
  output logic              stk_o,
  output logic              big_o,
  output logic              edge_o
);
  int               e;
  int               sh;
  logic [SIG_W-1:0] tmp;
  logic [SIG_W-1:0] low;

  assign e = int'($signed(uexp_i));

  always_comb begin
    mag_o  = '0;
    rnd_o  = 1'b0;
    stk_o  = 1'b0;
    big_o  = 1'b0;
    edge_o = (e == INT_W - 1);
    sh     = 0;
    tmp    = '0;
    low    = '0;
    if (e >= INT_W - 1) begin
      big_o = 1'b1;
    end else if (e >= FRAC_W) begin
      mag_o = INT_W'(sig_i) << (e - FRAC_W);
    end else if (e < -1) begin
      // whole value below one half: only a sticky remainder survives
      stk_o = |sig_i;
    end else begin
      sh    = FRAC_W - e;                 // 1 .. SIG_W
      mag_o = INT_W'(sig_i >> sh);
      tmp   = sig_i >> (sh - 1);
      rnd_o = tmp[0];
      low   = sig_i & ((SIG_W'(1) << (sh - 1)) - SIG_W'(1));
      stk_o = |low;
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic             sign_i,
  input  logic [1:0]       rm_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             rnd_i,
  input  logic             stk_i,
  output logic [INT_W-1:0] mag_o,
  output logic             ovf_o,
  output logic             inexact_o
);
  logic   inc;
  logic   lost;
  rmode_e mode;

  assign mode = rmode_e'(rm_i);
  assign lost = rnd_i | stk_i;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = rnd_i & (stk_i | mag_i[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = lost & ~sign_i;
      RM_DOWN: inc = lost & sign_i;
      default: inc = 1'b0;
    endcase
  end

  // rounding acts on the magnitude, before any negation
  assign mag_o     = mag_i + INT_W'(inc);
  assign ovf_o     = mag_o[INT_W-1];
  assign inexact_o = lost;
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        rm_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  result_o,
  output logic              invalid_o,
  output logic              inexact_o
);
  fdec_t             dec;
  logic [UEXP_W-1:0] uexp;
  logic [INT_W-1:0]  mag_a;
  logic              rnd_a, stk_a, big_a, edge_a;
  logic [INT_W-1:0]  mag_r;
  logic              ovf_r, lost_r;
  logic [INT_W-1:0]  sat_val;
  logic [INT_W-1:0]  res_d;
  logic              inv_d, inx_d;

  f2i_classify u_classify (
    .op_i   (op_i),
    .dec_o  (dec),
    .uexp_o (uexp)
  );

  f2i_align u_align (
    .sig_i  (dec.sig),
    .uexp_i (uexp),
    .mag_o  (mag_a),
    .rnd_o  (rnd_a),
    .stk_o  (stk_a),
    .big_o  (big_a),
    .edge_o (edge_a)
  );

  f2i_round u_round (
    .sign_i    (dec.sign),
    .rm_i      (rm_i),
    .mag_i     (mag_a),
    .rnd_i     (rnd_a),
    .stk_i     (stk_a),
    .mag_o     (mag_r),
    .ovf_o     (ovf_r),
    .inexact_o (lost_r)
  );

  assign sat_val = dec.sign ? NEG_LIM : POS_LIM;

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    inx_d = 1'b0;
    unique case (dec.cls)
      CL_NAN: begin
        res_d = NAN_VAL;
        inv_d = 1'b1;
      end
      CL_INF: begin
        res_d = sat_val;
        inv_d = 1'b1;
      end
      CL_ZERO: res_d = '0;
      default: begin
        if (big_a) begin
          if (edge_a && dec.sign && dec.sig == {1'b1, {FRAC_W{1'b0}}}) begin
            res_d = NEG_LIM;
          end else begin
            res_d = sat_val;
            inv_d = 1'b1;
          end
        end else if (ovf_r) begin
          res_d = sat_val;
          inv_d = 1'b1;
        end else begin
          res_d = dec.sign ? (~mag_r + INT_W'(1)) : mag_r;
          inx_d = lost_r;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      result_o  <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end

  AST_NAN_INDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(&op_i[FRAC_W +: EXP_W] && |op_i[FRAC_W-1:0])
      |-> invalid_o && !inexact_o && result_o == NAN_VAL); // R1
  AST_INF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(&op_i[FRAC_W +: EXP_W] && ~|op_i[FRAC_W-1:0])
      |-> invalid_o && result_o == ($past(op_i[OP_W-1]) ? NEG_LIM : POS_LIM)); // R2
  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(~|op_i[FRAC_W +: EXP_W])
      |-> result_o == '0 && !invalid_o && !inexact_o); // R3
  AST_SIGN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !invalid_o && result_o != '0
      |-> result_o[INT_W-1] == $past(op_i[OP_W-1])); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o); // R10
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R12
endmodule

// File: tb/f2i_conv_tb.sv
module f2i_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [1:0]  rm_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        invalid_o;
  logic        inexact_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        inx;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  f2i_conv u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .rm_i      (rm_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
  );

  localparam logic [63:0] PMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMIN = 64'h8000_0000_0000_0000;

  task automatic drive(input logic [31:0] op, input logic [1:0] rm,
                       input logic [63:0] res, input logic inv, input logic inx,
                       input string tag);
    exp_t it;
    @(negedge clk);
    op_i    = op;
    rm_i    = rm;
    valid_i = 1'b1;
    it.res = res; it.inv = inv; it.inx = inx; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: outputs registered at posedge, compared at the next negedge
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R12: valid_o with no pending item, actual %h expected none", result_o);
      end else begin
        exp_t it;
        it = q.pop_front();
        if (result_o !== it.res || invalid_o !== it.inv || inexact_o !== it.inx) begin
          n_fail++;
          $display("FAIL %s: actual %h inv=%b inx=%b expected %h inv=%b inx=%b",
                   it.tag, result_o, invalid_o, inexact_o, it.res, it.inv, it.inx);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (valid_o !== 1'b0 || result_o !== '0 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
          n_fail++;
          $display("FAIL R12 reset: actual v=%b %h %b %b expected 0", valid_o, result_o, invalid_o, inexact_o);
        end
        rst_n = 1'b1;
        // R5 exact
        drive(32'h3F80_0000, 2'b00, 64'd1, 0, 0, "R5");
        drive(32'hBF80_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5");
        drive(32'h5380_0000, 2'b00, 64'h0000_0100_0000_0000, 0, 0, "R5");
        drive(32'h5E80_0000, 2'b10, 64'h4000_0000_0000_0000, 0, 0, "R5");
        drive(32'h5EFF_FFFF, 2'b00, 64'h7FFF_FF80_0000_0000, 0, 0, "R5");
        drive(32'h4B00_0001, 2'b01, 64'h0000_0000_0080_0001, 0, 0, "R5");
        // R6 nearest
        drive(32'h4020_0000, 2'b00, 64'd2, 0, 1, "R6");
        drive(32'h4060_0000, 2'b00, 64'd4, 0, 1, "R6");
        drive(32'h3FC0_0000, 2'b00, 64'd2, 0, 1, "R6");
        drive(32'h3F40_0000, 2'b00, 64'd1, 0, 1, "R6");
        drive(32'hC020_0000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R6");
        drive(32'h4AFF_FFFF, 2'b00, 64'h0000_0000_0080_0000, 0, 1, "R6");
        drive(32'h3F00_0000, 2'b00, 64'd0, 0, 1, "R6");
        // R7 toward zero
        drive(32'h4020_0000, 2'b01, 64'd2, 0, 1, "R7");
        drive(32'hC020_0000, 2'b01, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R7");
        drive(32'h4AFF_FFFF, 2'b01, 64'h0000_0000_007F_FFFF, 0, 1, "R7");
        // R8 toward +inf
        drive(32'h4020_0000, 2'b10, 64'd3, 0, 1, "R8");
        drive(32'hC020_0000, 2'b10, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R8");
        drive(32'h3F00_0000, 2'b10, 64'd1, 0, 1, "R8");
        // R9 toward -inf
        drive(32'h4020_0000, 2'b11, 64'd2, 0, 1, "R9");
        drive(32'hC020_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1, "R9");
        drive(32'hBF00_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R9");
        drive(32'h3F00_0000, 2'b11, 64'd0, 0, 1, "R9");
        // R11 below one half
        drive(32'h3E80_0000, 2'b00, 64'd0, 0, 1, "R11");
        drive(32'h3E80_0000, 2'b10, 64'd1, 0, 1, "R11");
        drive(32'h8080_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R11");
        drive(32'h8080_0000, 2'b10, 64'd0, 0, 1, "R11");
        drive(32'hBE80_0000, 2'b01, 64'd0, 0, 1, "R11");
        // R10 flag on -0.5 nearest gives zero yet inexact
        drive(32'hBF00_0000, 2'b00, 64'd0, 0, 1, "R10");
        // R4 range limits
        drive(32'h5F00_0000, 2'b00, PMAX, 1, 0, "R4");
        drive(32'hDF00_0000, 2'b00, NMIN, 0, 0, "R4");
        drive(32'hDF00_0001, 2'b01, NMIN, 1, 0, "R4");
        drive(32'h7F7F_FFFF, 2'b11, PMAX, 1, 0, "R4");
        // R2 infinities
        drive(32'h7F80_0000, 2'b00, PMAX, 1, 0, "R2");
        drive(32'hFF80_0000, 2'b10, NMIN, 1, 0, "R2");
        // R1 NaNs
        drive(32'h7FC0_0000, 2'b00, PMAX, 1, 0, "R1");
        drive(32'hFF80_0001, 2'b11, PMAX, 1, 0, "R1");
        // R3 zero and subnormal
        drive(32'h0000_0000, 2'b10, 64'd0, 0, 0, "R3");
        drive(32'h8000_0000, 2'b11, 64'd0, 0, 0, "R3");
        drive(32'h0000_0001, 2'b10, 64'd0, 0, 0, "R3");
        drive(32'h807F_FFFF, 2'b11, 64'd0, 0, 0, "R3");
        @(negedge clk);
        valid_i = 1'b0;
        repeat (4) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
          n_fail++;
          $display("FAIL R12: items left %0d expected 0", q.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule